// File: doc/BRIEF.md
# Message FIFO Status Interrupt Logic

This block holds two byte-wide message queues, one feeding received message bytes toward a processor and one holding bytes the processor queues for transmission. Each queue's fill level is watched. Crossing a level, filling up, or an illegal access is turned into a two-bit condition code. A new code replaces both bits of its field at once.

The transmit side also raises a service request. A select input chooses what sets it. One choice is a message-done pulse. The other is the transmit queue draining from above half full to exactly half full.

The three fields are packed into one status word, which the processor reads through a strobe. The read clears every latched field. A per-bit mask decides which set bits pull the active-low interrupt line.

Top module: `msg_fifo_irq`

## Requirements
- R1: Receive code (status bits 4:3) becomes 01 when the receive fill rises from below 64 to 64 entries, 10 when it reaches 128 entries, and 11 when a write is attempted while it holds 128 entries.
- R2: Transmit code (status bits 2:1) becomes 01 when the transmit fill drops from 64 or more to below 64, 10 when a write is attempted while it holds 128 entries, and 11 when a read is attempted while it is empty and `tx_eom` is 0.
- R3: A read of the empty transmit queue while `tx_eom` is 1 leaves the status word unchanged.
- R4: Internal logic never writes 00 into a code field. A nonzero field keeps its value, except when a new condition replaces it or a status read clears it.
- R5: A cycle with `stat_rd` high clears all latched status bits on the next edge. A condition arriving in that same cycle is latched instead of being cleared.
- R6: Service request (status bit 0) sets on a `msg_done` pulse when `svc_sel` is 0. It sets on a transmit fill step from 65 to 64 entries when `svc_sel` is 1. The unselected event has no effect.
- R7: Status bits 7:5 always read 0. `stat_data` shows the latched word combinationally, and the word updates one clock after the event.
- R8: `irq_n` is low exactly when some status bit 4:0 is 1 and the `irq_mask` bit of the same position is 1.
- R9: Each queue returns bytes in write order. A write into a full queue is discarded with the contents unchanged. A read of an empty queue returns 0 and moves nothing.
- R10: After reset both queues are empty, read data is 0, the status word is 0 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_wr_en | input | 1 | Push a byte into the receive queue |
| rx_wr_data | input | 8 | Byte to push into the receive queue |
| rx_rd_en | input | 1 | Pop the receive queue |
| rx_rd_data | output | 8 | Head of the receive queue, 0 when empty |
| tx_wr_en | input | 1 | Push a byte into the transmit queue |
| tx_wr_data | input | 8 | Byte to push into the transmit queue |
| tx_rd_en | input | 1 | Pop the transmit queue |
| tx_rd_data | output | 8 | Head of the transmit queue, 0 when empty |
| tx_eom | input | 1 | End of message marker; suppresses the underflow code |
| msg_done | input | 1 | Message completed pulse |
| svc_sel | input | 1 | Service request source: 0 message done, 1 half-full crossing |
| irq_mask | input | 5 | Per-bit enable of status bits 4:0 onto the interrupt |
| stat_rd | input | 1 | Status read strobe; clears latched bits |
| stat_data | output | 8 | Packed status word |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The receive queue is filled one byte at a time past 63, 64, 128 and one write beyond. This separates the half, full and overflow codes and shows that the overflowing byte never appears in the drained data. The transmit queue is drained across 66, 65, 64 and 63 under both service-request selections. This tells the crossing-based request apart from the message-done request and from the below-half code. Empty reads with and without the end-of-message marker, and a status read in the same cycle as a new event, probe the underflow qualifier and the precedence of new events over clearing. Mask patterns of none, one and all-but-one bit show that the interrupt follows only the enabled bits.

// File: rtl/msgfifo_pkg.sv
`timescale 1ns/1ps
package msgfifo_pkg;
  localparam int STAT_W = 8;
  localparam int MASK_W = 5;

  typedef enum logic [1:0] {
    RX_LOW  = 2'b00,
    RX_HALF = 2'b01,
    RX_FULL = 2'b10,
    RX_OVF  = 2'b11
  } rx_code_e;

  typedef enum logic [1:0] {
    TX_HIGH = 2'b00,
    TX_LOW  = 2'b01,
    TX_OVF  = 2'b10,
    TX_UNF  = 2'b11
  } tx_code_e;

  typedef struct packed {
    logic       vld;
    logic [1:0] code;
  } evt_t;
endpackage

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] cnt,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          ovf,
  output logic          unf
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty;

  assign full  = (cnt_q == FULL_C);
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;
  assign ovf   = wr_en & full;
  assign unf   = rd_en & empty;
  assign cnt   = cnt_q;
  assign rd_data = empty ? '0 : mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_ok) wr_ptr_d = (wr_ptr_q == LAST_C) ? '0 : wr_ptr_q + 1'b1;
    if (rd_ok) rd_ptr_d = (rd_ptr_q == LAST_C) ? '0 : rd_ptr_q + 1'b1;
    if (wr_ok && !rd_ok)      cnt_d = cnt_q + 1'b1;
    else if (!wr_ok && rd_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= wr_ptr_d;
      if (rd_ok) rd_ptr_q <= rd_ptr_d;
      if (wr_ok ^ rd_ok) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wr_data;
  end
endmodule

// File: rtl/fifo_watch.sv
`timescale 1ns/1ps
module fifo_watch
  import msgfifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter bit IS_TX = 1'b0,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] cnt,
  input  logic          wr_ok,
  input  logic          rd_ok,
  input  logic          ovf,
  input  logic          unf,
  input  logic          eom,
  input  logic          msg_done,
  input  logic          svc_sel,
  output evt_t          evt,
  output logic          svc_evt
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (wr_ok && !rd_ok)      cnt_nxt = cnt + 1'b1;
    else if (!wr_ok && rd_ok) cnt_nxt = cnt - 1'b1;
  end

  if (IS_TX) begin : g_tx
    always_comb begin
      evt = '0;
      if (unf && !eom) begin
        evt.vld  = 1'b1;
        evt.code = TX_UNF;
      end else if (ovf) begin
        evt.vld  = 1'b1;
        evt.code = TX_OVF;
      end else if (cnt >= HALF_C && cnt_nxt < HALF_C) begin
        evt.vld  = 1'b1;
        evt.code = TX_LOW;
      end
      svc_evt = svc_sel ? (cnt > HALF_C && cnt_nxt == HALF_C) : msg_done;
    end
  end else begin : g_rx
    logic unused_rx;
    assign unused_rx = &{1'b0, unf, eom, msg_done, svc_sel};
    always_comb begin
      evt = '0;
      if (ovf) begin
        evt.vld  = 1'b1;
        evt.code = RX_OVF;
      end else if (cnt != FULL_C && cnt_nxt == FULL_C) begin
        evt.vld  = 1'b1;
        evt.code = RX_FULL;
      end else if (cnt < HALF_C && cnt_nxt >= HALF_C) begin
        evt.vld  = 1'b1;
        evt.code = RX_HALF;
      end
      svc_evt = 1'b0;
    end
  end
endmodule

// File: rtl/stat_latch.sv
`timescale 1ns/1ps
module stat_latch
  import msgfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  evt_t              rx_evt,
  input  evt_t              tx_evt,
  input  logic              svc_evt,
  input  logic              rd,
  input  logic [MASK_W-1:0] mask,
  output logic [STAT_W-1:0] word,
  output logic              irq_n
);
  logic [1:0] rx_q, rx_d, tx_q, tx_d;
  logic       svc_q, svc_d;
  logic       rx_en, tx_en, svc_en;

  always_comb begin
    rx_en  = rx_evt.vld | rd;
    tx_en  = tx_evt.vld | rd;
    svc_en = svc_evt | rd;
    rx_d   = rx_evt.vld ? rx_evt.code : 2'b00;
    tx_d   = tx_evt.vld ? tx_evt.code : 2'b00;
    svc_d  = svc_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 2'b00;
      tx_q  <= 2'b00;
      svc_q <= 1'b0;
    end else begin
      if (rx_en)  rx_q  <= rx_d;
      if (tx_en)  tx_q  <= tx_d;
      if (svc_en) svc_q <= svc_d;
    end
  end

  assign word  = {{(STAT_W - MASK_W){1'b0}}, rx_q, tx_q, svc_q};
  assign irq_n = ~|(word[MASK_W-1:0] & mask);
endmodule

// File: rtl/msg_fifo_irq.sv
`timescale 1ns/1ps
module msg_fifo_irq
  import msgfifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_wr_en,
  input  logic [DW-1:0]     rx_wr_data,
  input  logic              rx_rd_en,
  output logic [DW-1:0]     rx_rd_data,
  input  logic              tx_wr_en,
  input  logic [DW-1:0]     tx_wr_data,
  input  logic              tx_rd_en,
  output logic [DW-1:0]     tx_rd_data,
  input  logic              tx_eom,
  input  logic              msg_done,
  input  logic              svc_sel,
  input  logic [MASK_W-1:0] irq_mask,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_data,
  output logic              irq_n
);
  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_wr_ok, rx_rd_ok, rx_ovf, rx_unf;
  logic          tx_wr_ok, tx_rd_ok, tx_ovf, tx_unf;
  evt_t          rx_evt, tx_evt;
  logic          rx_svc, tx_svc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(rx_wr_en), .wr_data(rx_wr_data),
    .rd_en(rx_rd_en), .rd_data(rx_rd_data),
    .cnt(rx_cnt), .wr_ok(rx_wr_ok), .rd_ok(rx_rd_ok),
    .ovf(rx_ovf), .unf(rx_unf)
  );

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(tx_wr_en), .wr_data(tx_wr_data),
    .rd_en(tx_rd_en), .rd_data(tx_rd_data),
    .cnt(tx_cnt), .wr_ok(tx_wr_ok), .rd_ok(tx_rd_ok),
    .ovf(tx_ovf), .unf(tx_unf)
  );

  fifo_watch #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_watch (
    .cnt(rx_cnt), .wr_ok(rx_wr_ok), .rd_ok(rx_rd_ok),
    .ovf(rx_ovf), .unf(rx_unf), .eom(1'b0),
    .msg_done(1'b0), .svc_sel(1'b0),
    .evt(rx_evt), .svc_evt(rx_svc)
  );

  fifo_watch #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_watch (
    .cnt(tx_cnt), .wr_ok(tx_wr_ok), .rd_ok(tx_rd_ok),
    .ovf(tx_ovf), .unf(tx_unf), .eom(tx_eom),
    .msg_done(msg_done), .svc_sel(svc_sel),
    .evt(tx_evt), .svc_evt(tx_svc)
  );

  stat_latch u_stat (
    .clk(clk), .rst_n(rst_int_n),
    .rx_evt(rx_evt), .tx_evt(tx_evt),
    .svc_evt(tx_svc | rx_svc), .rd(stat_rd),
    .mask(irq_mask), .word(stat_data), .irq_n(irq_n)
  );
endmodule

module msg_fifo_irq_chk
  import msgfifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              rx_wr_en,
  input logic              rx_rd_en,
  input logic              tx_wr_en,
  input logic              tx_rd_en,
  input logic              tx_eom,
  input logic              msg_done,
  input logic              stat_rd,
  input logic [MASK_W-1:0] irq_mask,
  input logic [STAT_W-1:0] stat_data,
  input logic              irq_n,
  input logic [CW-1:0]     rx_cnt,
  input logic [CW-1:0]     tx_cnt
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    stat_data[STAT_W-1:MASK_W] == '0);

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stat_data[4:3] != 2'b00 && !stat_rd) |=> stat_data[4:3] != 2'b00);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stat_data[2:1] != 2'b00 && !stat_rd) |=> stat_data[2:1] != 2'b00);

  // R1
  rx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_wr_en && rx_cnt == FULL_C) |=> stat_data[4:3] == 2'b11);

  // R2
  tx_unf_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_rd_en && tx_cnt == '0 && !tx_eom) |=> stat_data[2:1] == 2'b11);

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stat_rd && !rx_wr_en && !rx_rd_en && !tx_wr_en && !tx_rd_en && !msg_done)
    |=> stat_data == '0);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_n |-> ((stat_data[MASK_W-1:0] & irq_mask) == '0));

  // R8
  irq_active_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq_n |-> ((stat_data[MASK_W-1:0] & irq_mask) != '0));

  // R9
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_wr_en && !rx_rd_en && rx_cnt == FULL_C) |=> rx_cnt == FULL_C);

  // R9
  tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_rd_en && !tx_wr_en && tx_cnt == '0) |=> tx_cnt == '0);
endmodule

bind msg_fifo_irq msg_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_msg_fifo_irq.sv
`timescale 1ns/1ps
module test_msg_fifo_irq;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_wr_en = 1'b0, rx_rd_en = 1'b0, tx_wr_en = 1'b0, tx_rd_en = 1'b0;
  logic [7:0] rx_wr_data = 8'h00, tx_wr_data = 8'h00;
  logic [7:0] rx_rd_data, tx_rd_data;
  logic       tx_eom = 1'b0, msg_done = 1'b0, svc_sel = 1'b0, stat_rd = 1'b0;
  logic [4:0] irq_mask = 5'b11111;
  logic [7:0] stat_data;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int rx_lvl = 0;
  int tx_lvl = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  always #2 clk = ~clk;

  msg_fifo_irq i_msg_fifo_irq (
    .clk(clk), .rst_n(rst_n),
    .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data),
    .tx_eom(tx_eom), .msg_done(msg_done), .svc_sel(svc_sel),
    .irq_mask(irq_mask), .stat_rd(stat_rd),
    .stat_data(stat_data), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: pushes expected bytes into the scoreboard queues
  task automatic rx_push(input logic [7:0] b);
    rx_wr_en = 1'b1;
    rx_wr_data = b;
    if (rx_lvl < DEPTH) begin
      rxq.push_back(b);
      rx_lvl++;
    end
    @(negedge clk);
    rx_wr_en = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] b);
    tx_wr_en = 1'b1;
    tx_wr_data = b;
    if (tx_lvl < DEPTH) begin
      txq.push_back(b);
      tx_lvl++;
    end
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic rx_pop();
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  task automatic tx_pop();
    tx_rd_en = 1'b1;
    @(negedge clk);
    tx_rd_en = 1'b0;
  endtask

  task automatic stat_read(input string tag, input logic [7:0] exp);
    stat_rd = 1'b1;
    chk(tag, stat_data, exp);
    @(negedge clk);
    stat_rd = 1'b0;
    chk({tag, " cleared (R5)"}, stat_data, 8'h00);
  endtask

  // monitor: pops the scoreboard and compares with read data (R9)
  always @(negedge clk) begin
    #1;
    if (rst_n && rx_rd_en) begin
      if (rxq.size() > 0) begin
        chk("R9 rx data order", rx_rd_data, rxq.pop_front());
        rx_lvl--;
      end else chk("R9 rx empty read", rx_rd_data, 8'h00);
    end
    if (rst_n && tx_rd_en) begin
      if (txq.size() > 0) begin
        chk("R9 tx data order", tx_rd_data, txq.pop_front());
        tx_lvl--;
      end else chk("R9 tx empty read", tx_rd_data, 8'h00);
    end
  end

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10
    chk("R10 status after reset", stat_data, 8'h00);
    chk("R10 irq after reset", irq_n, 1'b1);
    chk("R10 rx data empty", rx_rd_data, 8'h00);
    chk("R10 tx data empty", tx_rd_data, 8'h00);

    // R1 half and full codes
    for (int i = 0; i < 63; i++) rx_push(8'(i * 7 + 3));
    chk("R1 below half stays 00", stat_data, 8'h00);
    rx_push(8'h40);
    chk("R1 half code 01", stat_data, 8'h08);
    chk("R8 irq on rx half", irq_n, 1'b0);
    stat_read("R5 read rx half", 8'h08);
    chk("R8 irq released", irq_n, 1'b1);
    for (int i = 64; i < 128; i++) rx_push(8'(i * 5 + 1));
    chk("R1 full code 10", stat_data, 8'h10);
    rx_push(8'hEE);
    chk("R1 overflow code 11", stat_data, 8'h18);
    // R9 overflow byte discarded, order kept; R4 drain does not write 00
    for (int i = 0; i < 128; i++) rx_pop();
    chk("R4 rx code held after drain", stat_data, 8'h18);
    rx_pop();
    rx_push(8'h5A);
    rx_pop();
    chk("R4 rx code held after empty read", stat_data, 8'h18);
    stat_read("R5 read rx overflow", 8'h18);

    // R6 crossing-based service request, R2 below-half code
    svc_sel = 1'b1;
    for (int i = 0; i < 66; i++) tx_push(8'(i * 3 + 9));
    chk("R2 tx above half writes nothing", stat_data, 8'h00);
    tx_pop();
    chk("R6 66 to 65 no request", stat_data, 8'h00);
    tx_pop();
    chk("R6 65 to 64 sets request", stat_data, 8'h01);
    tx_pop();
    chk("R2 below half code 01", stat_data, 8'h03);

    // R5 new event in the read cycle wins
    svc_sel = 1'b0;
    stat_rd = 1'b1;
    msg_done = 1'b1;
    chk("R5 word during read", stat_data, 8'h03);
    @(negedge clk);
    stat_rd = 1'b0;
    msg_done = 1'b0;
    chk("R5 event beats clear", stat_data, 8'h01);

    // R8 masking
    irq_mask = 5'b00000;
    #1 chk("R8 all masked", irq_n, 1'b1);
    irq_mask = 5'b00001;
    #1 chk("R8 service bit enabled", irq_n, 1'b0);
    irq_mask = 5'b11110;
    #1 chk("R8 service bit masked", irq_n, 1'b1);
    irq_mask = 5'b11111;
    @(negedge clk);

    // R6 crossing ignored when message-done source selected
    stat_read("R5 read service", 8'h01);
    tx_push(8'hA1);
    tx_push(8'hA2);
    chk("R6 fill rising no event", stat_data, 8'h00);
    tx_pop();
    chk("R6 crossing ignored with svc_sel 0", stat_data, 8'h00);

    // drain to empty, then underflow cases
    for (int i = 0; i < 64; i++) tx_pop();
    chk("R2 below half after drain", stat_data, 8'h02);
    stat_read("R5 read tx low", 8'h02);
    tx_eom = 1'b1;
    tx_pop();
    chk("R3 underflow at end of message ignored", stat_data, 8'h00);
    tx_eom = 1'b0;
    tx_pop();
    chk("R2 underflow code 11", stat_data, 8'h06);
    chk("R8 irq on underflow", irq_n, 1'b0);
    stat_read("R5 read underflow", 8'h06);

    // R2 overflow, R9 overflow byte discarded
    for (int i = 0; i < 128; i++) tx_push(8'(i * 11 + 2));
    chk("R2 full writes nothing", stat_data, 8'h00);
    tx_push(8'h77);
    chk("R2 overflow code 10", stat_data, 8'h04);
    for (int i = 0; i < 128; i++) tx_pop();
    chk("R2 low code replaces overflow", stat_data, 8'h02);
    chk("R9 tx empty after drain", tx_rd_data, 8'h00);
    chk("R7 upper bits zero", stat_data[7:5], 3'b000);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule